// File: doc/BRIEF.md
# CAN Bit-Level Error Detector

This block runs beside a CAN protocol engine and sorts out bit-level faults at the sample point of every bit. The engine raises `bit_vld_i` once per bit, in the cycle where the sampled bus value is settled. In that cycle it also presents the value the node is driving, the value it sampled, and a set of flags. The flags say which part of the frame the bit belongs to, whether the node is the transmitter, and whether the node is in bus-off recovery. The block also takes the outcome of the CRC comparison.

There are six error outputs: stuff, bit-0, bit-1, CRC, form and missing-acknowledge. Each one pulses for a single cycle, and only in a strobe cycle. The only state in the block is a run-length tracker for the stuffed part of the frame. Every other classification is decided from the inputs of the current bit. The engine's error counters and fault-confinement logic use these pulses.

Bit monitoring is suppressed across the whole arbitration field. During bus-off recovery, every recessive bit that is received is reported as a bit-0 error.

Top module: `can_bit_err_det`

## Requirements
- R1: After reset all error outputs are low. An error output can only be high in a cycle where `bit_vld_i` is high, and each output pulses at most once per bit.
- R2: Recessive is logic 1 and dominant is logic 0. Inside the stuffed region (`stuff_region_i`=1), the sixth and every later consecutive received bit of the same value raises `stuff_err_o`.
- R3: The run length starts again at one whenever the received value changes. It also starts again on the first strobed bit of the stuffed region, so bits received outside the region never count toward a run.
- R4: `bit1_err_o` is raised when `transmitting_i`=1, the driven bit is 1 and the sampled bit is 0. The exceptions are arbitration-field bits and the acknowledge slot (`ack_slot_i`=1).
- R5: `bit0_err_o` is raised when `transmitting_i`=1, the driven bit is 0 and the sampled bit is 1, except on arbitration-field bits.
- R6: While `arb_field_i`=1 (identifier and remote-request bit), neither bit-monitoring error is raised outside bus-off recovery.
- R7: While `busoff_rec_i`=1, every received 1 raises `bit0_err_o`, whatever the driven bit, the transmitting flag or the arbitration flag.
- R8: `crc_err_o` is raised when the node is receiving (`transmitting_i`=0) at the bit marked by `crc_end_i` and `crc_match_i`=0.
- R9: `ack_err_o` is raised when the node is transmitting and samples a 1 in the acknowledge slot.
- R10: `form_err_o` is raised when a bit marked by `fixed_form_i` (a delimiter or end-of-frame bit that must be recessive) is sampled as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Sample-point strobe, one cycle per bit |
| tx_bit_i | input | 1 | Bit value the node drives |
| rx_bit_i | input | 1 | Bit value sampled from the bus |
| arb_field_i | input | 1 | Current bit belongs to the arbitration field |
| stuff_region_i | input | 1 | Current bit lies in the bit-stuffed region |
| transmitting_i | input | 1 | Node is the transmitter of the current frame |
| busoff_rec_i | input | 1 | Node is in bus-off recovery |
| ack_slot_i | input | 1 | Current bit is the acknowledge slot |
| crc_end_i | input | 1 | Current bit is where the CRC comparison result is valid |
| crc_match_i | input | 1 | Computed CRC equals the received CRC |
| fixed_form_i | input | 1 | Current bit is a fixed-form bit that must be recessive |
| stuff_err_o | output | 1 | Stuff error pulse |
| bit0_err_o | output | 1 | Bit-0 error pulse |
| bit1_err_o | output | 1 | Bit-1 error pulse |
| crc_err_o | output | 1 | CRC error pulse |
| form_err_o | output | 1 | Form error pulse |
| ack_err_o | output | 1 | Missing-acknowledge error pulse |

## Verification
The assertions assume the engine holds its inputs steady through each strobe cycle and asserts the phase flags only on bits where they make sense. In particular, `ack_slot_i` and `arb_field_i` are never both set, and `crc_end_i` marks one bit per frame. The stimulus table drives each classification with a single flag pattern per strobe, so these assumptions hold, and it includes idle cycles with the strobe low. The directed stuffed-region sequences leave the strobe high with a clean phase pattern. Region entry is exercised by dropping `stuff_region_i`, and reset is exercised by pulling `rst_ni` in the middle of a run.

// File: rtl/can_bit_err_pkg.sv
package can_bit_err_pkg;

  typedef struct packed {
    logic stuff;
    logic bit0;
    logic bit1;
    logic crc;
    logic form;
    logic ack;
  } err_vec_t;

  localparam logic RECESSIVE = 1'b1;
  localparam logic DOMINANT  = 1'b0;

endpackage

// File: rtl/can_stuff_mon.sv
module can_stuff_mon #(
  parameter int unsigned STUFF_LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic rx_bit_i,
  input  logic stuff_region_i,
  output logic stuff_err_o
);

  localparam int unsigned RUN_W = $clog2(STUFF_LIMIT + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(STUFF_LIMIT);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             last_q;
  logic             in_region_q;
  logic             restart;

  // run restarts at region entry or on a value change
  assign restart = !in_region_q || (rx_bit_i != last_q);

  always_comb begin
    if (restart)              run_d = RUN_ONE;
    else if (run_q == RUN_MAX) run_d = run_q;
    else                      run_d = run_q + RUN_ONE;
  end

  assign stuff_err_o = bit_vld_i && stuff_region_i && !restart && (run_q >= RUN_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      last_q      <= 1'b0;
      in_region_q <= 1'b0;
    end else if (bit_vld_i) begin
      if (stuff_region_i) begin
        run_q       <= run_d;
        last_q      <= rx_bit_i;
        in_region_q <= 1'b1;
      end else begin
        in_region_q <= 1'b0;
      end
    end
  end

  p_stuff_in_region_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> (stuff_region_i && in_region_q));

  p_run_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && stuff_region_i && !in_region_q) |=> (run_q == RUN_ONE));

  p_run_bounded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_MAX);

endmodule

// File: rtl/can_bit_mon.sv
module can_bit_mon
  import can_bit_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  input  logic arb_field_i,
  input  logic transmitting_i,
  input  logic busoff_rec_i,
  input  logic ack_slot_i,
  output logic bit0_err_o,
  output logic bit1_err_o
);

  logic mon_en;
  logic drv_dom_saw_rec;
  logic drv_rec_saw_dom;
  logic busoff_hit;

  assign mon_en          = bit_vld_i && transmitting_i && !arb_field_i;
  assign drv_dom_saw_rec = (tx_bit_i == DOMINANT) && (rx_bit_i == RECESSIVE);
  assign drv_rec_saw_dom = (tx_bit_i == RECESSIVE) && (rx_bit_i == DOMINANT);
  assign busoff_hit      = bit_vld_i && busoff_rec_i && (rx_bit_i == RECESSIVE);

  assign bit0_err_o = (mon_en && drv_dom_saw_rec) || busoff_hit;
  // a dominant ACK overwriting our recessive slot is the expected outcome
  assign bit1_err_o = mon_en && !ack_slot_i && drv_rec_saw_dom;

  p_arb_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_field_i && !busoff_rec_i) |-> (!bit0_err_o && !bit1_err_o));

  p_busoff_rec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && busoff_rec_i && rx_bit_i) |-> bit0_err_o);

  p_bit1_needs_tx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit1_err_o |-> (transmitting_i && tx_bit_i && !rx_bit_i));

endmodule

// File: rtl/can_frame_mon.sv
module can_frame_mon
  import can_bit_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic rx_bit_i,
  input  logic transmitting_i,
  input  logic ack_slot_i,
  input  logic crc_end_i,
  input  logic crc_match_i,
  input  logic fixed_form_i,
  output logic crc_err_o,
  output logic form_err_o,
  output logic ack_err_o
);

  assign crc_err_o  = bit_vld_i && !transmitting_i && crc_end_i && !crc_match_i;
  assign form_err_o = bit_vld_i && fixed_form_i && (rx_bit_i == DOMINANT);
  assign ack_err_o  = bit_vld_i && transmitting_i && ack_slot_i && (rx_bit_i == RECESSIVE);

  p_crc_rx_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> (!transmitting_i && crc_end_i));

  p_ack_tx_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> (transmitting_i && rx_bit_i));

  p_form_dom_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    form_err_o |-> (fixed_form_i && !rx_bit_i));

endmodule

// File: rtl/can_bit_err_det.sv
module can_bit_err_det
  import can_bit_err_pkg::*;
#(
  parameter int unsigned STUFF_LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  input  logic arb_field_i,
  input  logic stuff_region_i,
  input  logic transmitting_i,
  input  logic busoff_rec_i,
  input  logic ack_slot_i,
  input  logic crc_end_i,
  input  logic crc_match_i,
  input  logic fixed_form_i,
  output logic stuff_err_o,
  output logic bit0_err_o,
  output logic bit1_err_o,
  output logic crc_err_o,
  output logic form_err_o,
  output logic ack_err_o
);

  err_vec_t err;

  can_stuff_mon #(.STUFF_LIMIT(STUFF_LIMIT)) u_stuff (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bit_vld_i      (bit_vld_i),
    .rx_bit_i       (rx_bit_i),
    .stuff_region_i (stuff_region_i),
    .stuff_err_o    (err.stuff)
  );

  can_bit_mon u_bit (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bit_vld_i      (bit_vld_i),
    .tx_bit_i       (tx_bit_i),
    .rx_bit_i       (rx_bit_i),
    .arb_field_i    (arb_field_i),
    .transmitting_i (transmitting_i),
    .busoff_rec_i   (busoff_rec_i),
    .ack_slot_i     (ack_slot_i),
    .bit0_err_o     (err.bit0),
    .bit1_err_o     (err.bit1)
  );

  can_frame_mon u_frame (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bit_vld_i      (bit_vld_i),
    .rx_bit_i       (rx_bit_i),
    .transmitting_i (transmitting_i),
    .ack_slot_i     (ack_slot_i),
    .crc_end_i      (crc_end_i),
    .crc_match_i    (crc_match_i),
    .fixed_form_i   (fixed_form_i),
    .crc_err_o      (err.crc),
    .form_err_o     (err.form),
    .ack_err_o      (err.ack)
  );

  assign stuff_err_o = err.stuff;
  assign bit0_err_o  = err.bit0;
  assign bit1_err_o  = err.bit1;
  assign crc_err_o   = err.crc;
  assign form_err_o  = err.form;
  assign ack_err_o   = err.ack;

  p_pulse_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |-> (err == '0));

  p_bit_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit0_err_o && bit1_err_o));

endmodule

// File: tb/can_bit_err_det_tb.sv
module can_bit_err_det_tb;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_vld_i = 1'b0, tx_bit_i = 1'b1, rx_bit_i = 1'b1, arb_field_i = 1'b0;
  logic stuff_region_i = 1'b0, transmitting_i = 1'b0, busoff_rec_i = 1'b0;
  logic ack_slot_i = 1'b0, crc_end_i = 1'b0, crc_match_i = 1'b0, fixed_form_i = 1'b0;
  logic stuff_err_o, bit0_err_o, bit1_err_o, crc_err_o, form_err_o, ack_err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  can_bit_err_det u_dut (.*);

  // {tag[3:0], vld,tx,rx,arb,stf,trn,bof,ack,crce,crcm,fix, exp stuff,b0,b1,crc,form,ack}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {4'd1,  11'b0_0_1_0_0_1_0_0_0_0_0, 6'b000000},  // R1 no strobe
    {4'd5,  11'b1_0_1_0_0_1_0_0_0_0_0, 6'b010000},  // R5
    {4'd4,  11'b1_1_0_0_0_1_0_0_0_0_0, 6'b001000},  // R4
    {4'd6,  11'b1_1_0_1_0_1_0_0_0_0_0, 6'b000000},  // R6
    {4'd6,  11'b1_0_1_1_0_1_0_0_0_0_0, 6'b000000},  // R6
    {4'd4,  11'b1_1_0_0_0_1_0_1_0_0_0, 6'b000000},  // R4 ack slot
    {4'd9,  11'b1_1_1_0_0_1_0_1_0_0_0, 6'b000001},  // R9
    {4'd9,  11'b1_1_1_0_0_0_0_1_0_0_0, 6'b000000},  // R9 receiver
    {4'd7,  11'b1_1_1_1_0_0_1_0_0_0_0, 6'b010000},  // R7
    {4'd7,  11'b1_0_0_0_0_0_1_0_0_0_0, 6'b000000},  // R7 dominant
    {4'd8,  11'b1_1_1_0_0_0_0_0_1_0_0, 6'b000100},  // R8
    {4'd8,  11'b1_1_1_0_0_0_0_0_1_1_0, 6'b000000},  // R8 match
    {4'd8,  11'b1_1_1_0_0_1_0_0_1_0_0, 6'b000000},  // R8 transmitter
    {4'd10, 11'b1_0_0_0_0_0_0_0_0_0_1, 6'b000010},  // R10
    {4'd10, 11'b1_1_1_0_0_0_0_0_0_0_1, 6'b000000},  // R10 recessive
    {4'd10, 11'b1_0_0_0_0_1_0_0_0_0_1, 6'b000010}   // R10 while sending
  };

  function automatic logic [5:0] got_vec();
    return {stuff_err_o, bit0_err_o, bit1_err_o, crc_err_o, form_err_o, ack_err_o};
  endfunction

  task automatic chk(input string tag, input logic [5:0] exp);
    checks++;
    if (got_vec() !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got_vec(), exp);
    end
  endtask

  task automatic idle();
    bit_vld_i = 0; tx_bit_i = 1; rx_bit_i = 1; arb_field_i = 0; stuff_region_i = 0;
    transmitting_i = 0; busoff_rec_i = 0; ack_slot_i = 0; crc_end_i = 0;
    crc_match_i = 0; fixed_form_i = 0;
  endtask

  // one received bit, receiver only, checked before the capturing edge
  task automatic rx_bit(input logic stf, input logic v, input logic exp_stuff, input string tag);
    @(negedge clk_i);
    idle();
    bit_vld_i = 1; stuff_region_i = stf; rx_bit_i = v; tx_bit_i = v;
    #1;
    chk(tag, {exp_stuff, 5'b0});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset", 6'b0);
    rst_ni = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {bit_vld_i, tx_bit_i, rx_bit_i, arb_field_i, stuff_region_i, transmitting_i,
       busoff_rec_i, ack_slot_i, crc_end_i, crc_match_i, fixed_form_i} = VEC[i][16:6];
      #1;
      checks++;
      if (got_vec() !== VEC[i][5:0]) begin
        errors++;
        $display("FAIL R%0d vec %0d got=%b exp=%b", VEC[i][20:17], i, got_vec(), VEC[i][5:0]);
      end
    end

    // R2: sixth and later equal bits flag
    for (int i = 0; i < 5; i++) rx_bit(1, 0, 0, "R2 run<=5");
    rx_bit(1, 0, 1, "R2 sixth zero");
    rx_bit(1, 0, 1, "R2 seventh zero");
    // R3: change restarts run
    rx_bit(1, 1, 0, "R3 value change");
    for (int i = 0; i < 4; i++) rx_bit(1, 1, 0, "R3 ones<=5");
    rx_bit(1, 1, 1, "R2 sixth one");

    // R3: bits outside region do not count
    for (int i = 0; i < 3; i++) rx_bit(0, 0, 0, "R3 outside");
    for (int i = 0; i < 5; i++) rx_bit(1, 0, 0, "R3 entry restart");
    rx_bit(1, 0, 1, "R2 after entry");

    // R1: strobe low does not advance or flag
    @(negedge clk_i); idle(); rx_bit_i = 0; stuff_region_i = 1; #1;
    chk("R1 strobe low", 6'b0);

    // R1/R3: reset mid-run clears state
    for (int i = 0; i < 4; i++) rx_bit(1, 1, 0, "R3 pre-reset");
    @(negedge clk_i); idle(); rst_ni = 0;
    @(negedge clk_i); chk("R1 in reset", 6'b0); rst_ni = 1;
    for (int i = 0; i < 5; i++) rx_bit(1, 1, 0, "R3 post-reset");
    rx_bit(1, 1, 1, "R2 post-reset sixth");

    @(negedge clk_i); idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule